// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a 12-bit narrow port and a 24-bit wide port, one clock for all of it. The wide port is made of two 12-bit halves, an upper-path half (lane 1) and a lower-path half (lane 2). In the narrow-to-wide direction it packs two narrow words that arrive one after the other into a single wide word. Lane 1 sits behind a two-register pipeline and lane 2 behind a single register. If lane 1 is enabled on one edge, and both lanes are enabled on the next, the earlier word shows up on lane 1 and the later word on lane 2, both at once.

In the wide-to-narrow direction each half is caught in its own register. A select bit, registered on the same edge, picks which stored half is driven back onto the narrow port. Every storage register has its own active-low load enable. The drive enables for both ports are active low and registered, so the drive direction only changes at a clock edge. Tri-state pins are split into separate data-out and drive-enable signals.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register is cleared and the select register is cleared. After that edge, `a_out`, `b1_out` and `b2_out` read 0, and `a_drv` and `b_drv` read 0 (not driving).
- R2: A register whose own active-low enable is high at a rising edge keeps its value. So `b1_out` holds while `ld_a1_n` is 1, `b2_out` holds while `ld_a2_n` is 1, and a stored wide half holds while its `ld_b1_n` or `ld_b2_n` is 1.
- R3: Lane 1 has two stages, and `ld_a1_n` moves both of them together. After an edge with `ld_a1_n`=0, `b1_out` equals the `a_in` value captured at the previous edge that had `ld_a1_n`=0.
- R4: After an edge with `ld_a2_n`=0, `b2_out` equals the `a_in` value sampled at that edge.
- R5: Take an edge with `ld_a1_n`=0, `ld_a2_n`=1 and `a_in`=W0, then the next edge with both enables 0 and `a_in`=W1. After that, `b1_out`=W0 and `b2_out`=W1 are presented together.
- R6: `b1_in` is stored at an edge with `ld_b1_n`=0, and `b2_in` at an edge with `ld_b2_n`=0. The two are independent of each other.
- R7: `sel` is registered on every edge. After an edge with `sel`=1, `a_out` shows the stored lane-1 half; after an edge with `sel`=0 it shows the stored lane-2 half. The latency from capture to `a_out` is one clock.
- R8: After each edge outside reset, `a_drv` equals the inverse of `oe_a_n` and `b_drv` the inverse of `oe_b_n` as sampled at that edge. The two are independent, and all four combinations can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Narrow port incoming data |
| a_out | output | 12 | Narrow port outgoing data (selected stored half) |
| a_drv | output | 1 | Narrow port drive enable, 1 = drive |
| b1_in | input | 12 | Wide lane 1 incoming data |
| b2_in | input | 12 | Wide lane 2 incoming data |
| b1_out | output | 12 | Wide lane 1 outgoing data |
| b2_out | output | 12 | Wide lane 2 outgoing data |
| b_drv | output | 1 | Wide port drive enable, 1 = drive |
| ld_a1_n | input | 1 | Active-low load for both lane-1 pipeline stages |
| ld_a2_n | input | 1 | Active-low load for the lane-2 register |
| ld_b1_n | input | 1 | Active-low load for the stored lane-1 half |
| ld_b2_n | input | 1 | Active-low load for the stored lane-2 half |
| sel | input | 1 | Half select for the narrow port, 1 = lane 1 |
| oe_a_n | input | 1 | Active-low narrow port drive request |
| oe_b_n | input | 1 | Active-low wide port drive request |

## Verification
Random cycles toggle every enable and the select on their own. This separates a lane-1 pipeline that advances as a unit from one whose stages move apart, and tells a held register from one that loads anyway. Directed sequences apply the two-word packing order, a lane-1-only run that shows the two-edge delay, and each select value with only one half freshly loaded, so that a swapped multiplexer becomes visible. A mid-run reset and a walk through all four drive-request combinations check the cleared state and the independence of the two drive enables.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int unsigned LANE_W_DEF = 12;

    typedef enum logic {
        HALF_LANE2 = 1'b0,
        HALF_LANE1 = 1'b1
    } half_sel_e;

    typedef struct packed {
        logic a_on;
        logic b_on;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{a_on: 1'b0, b_on: 1'b0};

    function automatic drive_t decode_req(input logic req_a_n, input logic req_b_n);
        drive_t d;
        d.a_on = ~req_a_n;
        d.b_on = ~req_b_n;
        return d;
    endfunction
endpackage

// File: rtl/bx_pack_path.sv
module bx_pack_path #(
    parameter int unsigned LANE_W = 12,
    parameter int unsigned L1_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] narrow_in,
    input  logic              ld1_n,
    input  logic              ld2_n,
    output logic [LANE_W-1:0] lane1_q,
    output logic [LANE_W-1:0] lane2_q
);
    localparam int unsigned LAST = L1_STAGES - 1;

    logic [LANE_W-1:0] stage_q [L1_STAGES];

    for (genvar g = 0; g < L1_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[g] <= '0;
            else if (!ld1_n)
                stage_q[g] <= (g == 0) ? narrow_in : stage_q[(g == 0) ? 0 : g - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lane2_q <= '0;
        else if (!ld2_n)
            lane2_q <= narrow_in;
    end

    assign lane1_q = stage_q[LAST];

    a_r2_lane1_hold: assert property (@(posedge clk) disable iff (rst)
        ld1_n |=> $stable(lane1_q));
    a_r4_lane2_load: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> lane2_q == $past(narrow_in));
    a_r2_lane2_hold: assert property (@(posedge clk) disable iff (rst)
        ld2_n |=> $stable(lane2_q));
endmodule

// File: rtl/bx_unpack_path.sv
module bx_unpack_path
    import bx_pkg::*;
#(
    parameter int unsigned LANE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] lane1_in,
    input  logic [LANE_W-1:0] lane2_in,
    input  logic              ld1_n,
    input  logic              ld2_n,
    input  logic              sel,
    output logic [LANE_W-1:0] narrow_q
);
    logic [LANE_W-1:0] held1_q, held2_q;
    half_sel_e         pick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held1_q <= '0;
            held2_q <= '0;
            pick_q  <= HALF_LANE2;
        end else begin
            if (!ld1_n) held1_q <= lane1_in;
            if (!ld2_n) held2_q <= lane2_in;
            pick_q <= half_sel_e'(sel);
        end
    end

    always_comb begin
        unique case (pick_q)
            HALF_LANE1: narrow_q = held1_q;
            default:    narrow_q = held2_q;
        endcase
    end

    a_r7_pick_lane1: assert property (@(posedge clk) disable iff (rst)
        (sel && !ld1_n) |=> narrow_q == $past(lane1_in));
    a_r7_pick_lane2: assert property (@(posedge clk) disable iff (rst)
        (!sel && !ld2_n) |=> narrow_q == $past(lane2_in));
    a_r6_hold_pick: assert property (@(posedge clk) disable iff (rst)
        (ld1_n && ld2_n && $past(sel) == sel) |=> $stable(narrow_q));
endmodule

// File: rtl/bx_drive_ctl.sv
module bx_drive_ctl
    import bx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_a_n,
    input  logic   req_b_n,
    output drive_t drv_q
);
    always_ff @(posedge clk) begin
        if (rst) drv_q <= DRIVE_OFF;
        else     drv_q <= decode_req(req_a_n, req_b_n);
    end

    a_r1_drive_off: assert property (@(posedge clk)
        rst |=> (drv_q == DRIVE_OFF));
    a_r8_b_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drv_q.b_on == !$past(req_b_n));
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] a_in,
    output logic [LANE_W-1:0] a_out,
    output logic              a_drv,
    input  logic [LANE_W-1:0] b1_in,
    input  logic [LANE_W-1:0] b2_in,
    output logic [LANE_W-1:0] b1_out,
    output logic [LANE_W-1:0] b2_out,
    output logic              b_drv,
    input  logic              ld_a1_n,
    input  logic              ld_a2_n,
    input  logic              ld_b1_n,
    input  logic              ld_b2_n,
    input  logic              sel,
    input  logic              oe_a_n,
    input  logic              oe_b_n
);
    drive_t drv;

    bx_pack_path #(.LANE_W(LANE_W), .L1_STAGES(2)) u_pack (
        .clk(clk), .rst(rst), .narrow_in(a_in),
        .ld1_n(ld_a1_n), .ld2_n(ld_a2_n),
        .lane1_q(b1_out), .lane2_q(b2_out)
    );

    bx_unpack_path #(.LANE_W(LANE_W)) u_unpack (
        .clk(clk), .rst(rst), .lane1_in(b1_in), .lane2_in(b2_in),
        .ld1_n(ld_b1_n), .ld2_n(ld_b2_n), .sel(sel), .narrow_q(a_out)
    );

    bx_drive_ctl u_drive (
        .clk(clk), .rst(rst), .req_a_n(oe_a_n), .req_b_n(oe_b_n), .drv_q(drv)
    );

    assign a_drv = drv.a_on;
    assign b_drv = drv.b_on;

    a_r1_data_clear: assert property (@(posedge clk)
        rst |=> (a_out == '0 && b1_out == '0 && b2_out == '0));
    a_r8_a_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> a_drv == !$past(oe_a_n));
    a_r5_pair: assert property (@(posedge clk) disable iff (rst)
        (!ld_a1_n && ld_a2_n) |=> (!ld_a1_n && !ld_a2_n) |=> b1_out == $past(a_in, 2));
endmodule

// File: tb/bus_exchanger_tb_top.sv
module bus_exchanger_tb_top;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_drv, b_drv;
    logic ld_a1_n, ld_a2_n, ld_b1_n, ld_b2_n, sel, oe_a_n, oe_b_n;

    always #2 clk = ~clk;

    bus_exchanger #(.LANE_W(W)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out), .b_drv(b_drv),
        .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n), .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
        .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] m_s1, m_s2, m_l2, m_h1, m_h2;
    logic m_sel, m_da, m_db;

    function automatic logic [W-1:0] exp_narrow(input logic s, input logic [W-1:0] h1,
                                                input logic [W-1:0] h2);
        return s ? h1 : h2;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R3/R5 b1_out", b1_out, m_s2);
        check("R4 b2_out", b2_out, m_l2);
        check("R6/R7 a_out", a_out, exp_narrow(m_sel, m_h1, m_h2));
        check("R8 a_drv", W'(a_drv), W'(m_da));
        check("R8 b_drv", W'(b_drv), W'(m_db));
    endtask

    // advance one edge; expected state follows the requirements
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_l2 = '0; m_h1 = '0; m_h2 = '0;
            m_sel = 1'b0; m_da = 1'b0; m_db = 1'b0;
        end else begin
            if (!ld_a1_n) begin m_s2 = m_s1; m_s1 = a_in; end
            if (!ld_a2_n) m_l2 = a_in;
            if (!ld_b1_n) m_h1 = b1_in;
            if (!ld_b2_n) m_h2 = b2_in;
            m_sel = sel; m_da = !oe_a_n; m_db = !oe_b_n;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        ld_a1_n = 1; ld_a2_n = 1; ld_b1_n = 1; ld_b2_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; a_in = '0; b1_in = '0; b2_in = '0; sel = 0; oe_a_n = 0; oe_b_n = 0;
        idle();
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        check("R1 a_out", a_out, '0);
        check("R1 b1_out", b1_out, '0);
        check("R1 b2_out", b2_out, '0);
        check("R1 drive", W'({a_drv, b_drv}), '0);
        rst = 0;

        // R5 directed packing
        a_in = 12'h111; ld_a1_n = 0; ld_a2_n = 1; tick();
        a_in = 12'h222; ld_a1_n = 0; ld_a2_n = 0; tick();
        idle(); a_in = 12'hFFF; tick();
        check("R5 b1_out", b1_out, 12'h111);
        check("R5 b2_out", b2_out, 12'h222);
        // R2 hold with enables high
        tick();
        check("R2 b1_out hold", b1_out, 12'h111);

        // R3 lane-1 only: two edges needed
        a_in = 12'h3A5; ld_a1_n = 0; tick();
        check("R3 not yet", b1_out, 12'h222);
        a_in = 12'h000; tick();
        check("R3 arrived", b1_out, 12'h3A5);
        idle();

        // R7 select with one half fresh
        b1_in = 12'hABC; b2_in = 12'h123; ld_b1_n = 0; sel = 1; tick();
        check("R7 sel=1", a_out, 12'hABC);
        idle(); b2_in = 12'h456; ld_b2_n = 0; sel = 0; tick();
        check("R7 sel=0", a_out, 12'h456);
        idle(); b1_in = 12'h999; b2_in = 12'h999; tick();
        check("R6 hold", a_out, 12'h456);

        // R8 all four drive combinations
        for (int k = 0; k < 4; k++) begin
            oe_a_n = k[0]; oe_b_n = k[1];
            check("R8 pre-edge a", W'(a_drv), W'(m_da));
            tick();
            check("R8 a_drv", W'(a_drv), W'(!k[0]));
            check("R8 b_drv", W'(b_drv), W'(!k[1]));
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
            ld_a1_n = $urandom_range(0, 2) == 0; ld_a2_n = $urandom_range(0, 2) == 0;
            ld_b1_n = $urandom_range(0, 1) == 0; ld_b2_n = $urandom_range(0, 1) == 0;
            sel = 1'($urandom); oe_a_n = 1'($urandom); oe_b_n = 1'($urandom);
            rst = (i == 1500);
            tick();
            check_all();
            if (i == 1500) begin
                check("R1 mid-run b1", b1_out, '0);
                check("R1 mid-run a", a_out, '0);
            end
        end
        rst = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule